// File: doc/BRIEF.md
# Frame and Subframe Timing Generator

This block splits time into repeating frames of 1004 active-clock cycles. Each frame holds an active window of 1000 cycles followed by a four-cycle gap. Within the window it marks four evenly spaced subframe starts. A downstream pipeline uses the window flag to gate its work, and it uses the two start pulses to align its bursts.

The frame position is kept in a signed counter that climbs from minus the window length up to a small positive terminal value. Its sign bit is the window flag, so no full-width compare is needed. The terminal value is decoded from the sign bit and the low bits only. A second, narrower signed counter counts down inside the window. When it goes negative, a new subframe starts. Each frame wrap reloads it. A run input freezes the whole block when low. While it is low, both counters hold their values and no pulses are emitted.

Top module: `frame_tg_gen`

## Requirements
- R1: While reset is high and for the first cycle after it is released, the block is at frame position 0. If run is high in that cycle, `en_o`, `frame_start_o` and `sub_start_o` are all 1.
- R2: Counted in run cycles, `en_o` is 1 for frame positions 0..999 and 0 for positions 1000..1003. The frame then repeats with a period of 1004.
- R3: `frame_start_o` is 1 exactly in run cycles at frame position 0, and 0 in every other cycle.
- R4: `sub_start_o` is 1 exactly in run cycles at frame positions 0, 250, 500 and 750, and 0 in every other cycle, including the gap.
- R5: In a cycle with run low, both start pulses are 0 and the frame position does not advance. `en_o` keeps the value of the held position, and the sequence resumes unchanged when run returns.
- R6: `sub_start_o` is never 1 while `en_o` is 0, and every `frame_start_o` coincides with a `sub_start_o`.
- R7: Reset asserted in the middle of a frame returns the block to frame position 0 on the next clock edge, whatever the counter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Advance enable; low freezes the block |
| en_o | output | 1 | Active-window flag (sign of the frame counter) |
| frame_start_o | output | 1 | One-cycle pulse at the first cycle of each frame |
| sub_start_o | output | 1 | One-cycle pulse at each subframe start |

## Verification
Suppose the frame counter loads a wrong value or its terminal decode misses. The error then shows on `en_o` as a window that is too long or too short. It is visible within one frame, at the first gap, which comes at most 1004 run cycles after the fault. An error in the reload or underflow of the subframe counter moves a `sub_start_o` pulse away from its multiple of 250. The pulse can also appear in the gap, so the error shows within 250 run cycles. A freeze that leaks would let the frame position move while run is low. That offsets every later pulse and the next window edge, so the per-cycle comparison against a position model catches it in the very next run cycle that has an edge.

// File: rtl/frame_tg_pkg.sv
package frame_tg_pkg;

  // Width of a signed counter able to hold -n and small positives.
  function automatic int signed_width(input int n);
    return $clog2(n) + 1;
  endfunction

  // Two's complement pattern of -n in a w-bit field.
  function automatic int neg_pattern(input int n, input int w);
    return (1 << w) - n;
  endfunction

endpackage

// File: rtl/frame_tg_main.sv
module frame_tg_main
  import frame_tg_pkg::*;
#(
  parameter int ACTIVE = 1000,
  parameter int TAIL   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic window_o,
  output logic wrap_o,
  output logic first_o
);
  localparam int W      = signed_width(ACTIVE);
  localparam int TBITS  = $clog2(TAIL);
  localparam logic [W-1:0] START = W'(neg_pattern(ACTIVE, W));

  logic [W-1:0] pos_q;
  logic         first_q;
  logic         at_term;

  // Terminal value TAIL-1: sign clear and low bits all ones.
  assign at_term  = ~pos_q[W-1] & (&pos_q[TBITS-1:0]);
  assign wrap_o   = run_i & at_term;
  assign window_o = pos_q[W-1];
  assign first_o  = first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= START;
      first_q <= 1'b1;
    end else if (run_i) begin
      pos_q   <= at_term ? START : pos_q + 1'b1;
      first_q <= at_term;
    end
  end
endmodule

// File: rtl/frame_tg_sub.sv
module frame_tg_sub
  import frame_tg_pkg::*;
#(
  parameter int PERIOD = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic reload_i,
  output logic under_o
);
  localparam int W = signed_width(PERIOD);
  localparam logic [W-1:0] LOAD_FRAME = W'(PERIOD - 1);
  // The -1 cycle itself stands in for the top value, hence one less.
  localparam logic [W-1:0] LOAD_UNDER = W'(PERIOD - 2);

  logic [W-1:0] cnt_q;

  assign under_o = cnt_q[W-1];

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= LOAD_FRAME;
    else if (run_i) begin
      if (reload_i)        cnt_q <= LOAD_FRAME;
      else if (cnt_q[W-1]) cnt_q <= LOAD_UNDER;
      else                 cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/frame_tg_gen.sv
module frame_tg_gen #(
  parameter int ACTIVE = 1000,
  parameter int TAIL   = 4,
  parameter int PERIOD = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic en_o,
  output logic frame_start_o,
  output logic sub_start_o
);
  logic frame_wrap;
  logic frame_first;
  logic sub_under;

  frame_tg_main #(.ACTIVE(ACTIVE), .TAIL(TAIL)) u_main (
    .clk(clk), .rst(rst), .run_i(run_i),
    .window_o(en_o), .wrap_o(frame_wrap), .first_o(frame_first)
  );

  frame_tg_sub #(.PERIOD(PERIOD)) u_sub (
    .clk(clk), .rst(rst), .run_i(run_i),
    .reload_i(frame_wrap), .under_o(sub_under)
  );

  assign frame_start_o = run_i & frame_first;
  assign sub_start_o   = run_i & (frame_first | (sub_under & en_o));
endmodule

// File: rtl/frame_tg_chk.sv
module frame_tg_chk #(
  parameter int TAIL = 4
) (
  input logic clk,
  input logic rst,
  input logic run_i,
  input logic en_o,
  input logic frame_start_o,
  input logic sub_start_o,
  input logic wrap,
  input logic under
);
  logic [7:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (run_i && !en_o) gap_q <= gap_q + 1'b1;
    else if (run_i)          gap_q <= '0;
  end

  assert_gap_len_R2: assert property (@(posedge clk) disable iff (rst)
    gap_q <= 8'(TAIL));

  assert_wrap_starts_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (!run_i || frame_start_o));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !run_i |-> (!frame_start_o && !sub_start_o));

  assert_hold_window_R5: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> $stable(en_o));

  assert_sub_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    sub_start_o |-> en_o);

  assert_frame_has_sub_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> sub_start_o);

  assert_under_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (under && !en_o) |-> !sub_start_o);
endmodule

bind frame_tg_gen frame_tg_chk #(.TAIL(TAIL)) u_chk (
  .clk(clk), .rst(rst), .run_i(run_i), .en_o(en_o),
  .frame_start_o(frame_start_o), .sub_start_o(sub_start_o),
  .wrap(frame_wrap), .under(sub_under)
);

// File: tb/tb_frame_tg_gen.sv
`timescale 1ns/1ps
module tb_frame_tg_gen;
  localparam int FRAME = 1004;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic en, fs, ss;

  int n_vec  = 0;
  int n_fail = 0;
  int pos    = 0;
  logic fresh = 1'b1;
  int unused_seed;

  frame_tg_gen dut (.clk(clk), .rst(rst), .run_i(run),
                    .en_o(en), .frame_start_o(fs), .sub_start_o(ss));

  always #10 clk = ~clk;

  function automatic logic want_en(input int p);
    return p < 1000;
  endfunction
  function automatic logic want_fs(input int p, input logic r);
    return r && (p == 0);
  endfunction
  function automatic logic want_ss(input int p, input logic r);
    return r && (p < 1000) && (p % 250 == 0);
  endfunction

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s pos=%0d run=%0b actual=%0b expected=%0b", req, nm, pos, run, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic ru, input string tag);
    @(negedge clk);
    rst = r; run = ru;
    #2;
    if (!r) begin
      chk(fresh ? "R1" : (ru ? "R2" : "R5"), "en", en, want_en(pos));
      chk(fresh ? "R1" : (ru ? "R3" : "R5"), "frame_start", fs, want_fs(pos, ru));
      chk(fresh ? "R1" : (ru ? "R4" : "R5"), "sub_start", ss, want_ss(pos, ru));
      chk(tag.len() != 0 ? tag : "R6", "sub_without_en", ss && !en, 1'b0);
    end
    @(posedge clk);
    if (r) begin pos = 0; fresh = 1'b1; end
    else if (ru) begin pos = (pos == FRAME - 1) ? 0 : pos + 1; fresh = 1'b0; end
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    unused_seed = $urandom(32'h5eed_0042);
    // R1: reset state, then directed idle cycles at position 0 (R5)
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R1");
    // R2 R3 R4: two unbroken frames
    for (int i = 0; i < 2 * FRAME; i++) step(1'b0, 1'b1, "");
    // R5: freeze across a subframe boundary and across the gap
    while (pos != 250) step(1'b0, 1'b1, "");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R5");
    while (pos != 1001) step(1'b0, 1'b1, "");
    for (int i = 0; i < 15; i++) step(1'b0, 1'b0, "R5");
    // Random run pattern over several frames
    for (int i = 0; i < 5000; i++) step(1'b0, ($urandom % 10) != 0, "");
    // R7: reset mid-frame
    while (pos != 600) step(1'b0, 1'b1, "");
    step(1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    for (int i = 0; i < FRAME + 300; i++) step(1'b0, ($urandom % 8) != 0, "");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule